// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit carries out a single bitfield instruction on a field held in byte-addressed memory. A field is named by a byte base address, a signed bit offset and a width. Bits are numbered from the most significant bit of each byte and run on into following bytes, so a field can cross byte boundaries and can begin before the base byte when the offset is negative. The unit works out which bytes hold the field and widens that span to a container of 1, 2, 4 or 8 bytes. It reads the container and applies the requested operation. For operations that modify the field it writes the container back, and it keeps the bus locked from the read to the write.

The operations are signed extract, unsigned extract, insert, invert, clear, set and find-first-one. Each gives a result word and a flag source word from which a condition-code stage takes its N and Z flags. A caller raises `start` for one cycle with the operands. It then waits for the one-cycle `done` pulse, and the outputs stay valid from that pulse until the next one.

Top module: `bitfield_mem_unit`

## Requirements
- R1: `width_in` is 6 bits wide and only its low 5 bits are used. A value of 0 in those bits selects a 32-bit field, so 32 means 32 and 33 means 1.
- R2: The first field bit is at byte `base_addr + floor(bit_ofs/8)`, bit position `bit_ofs mod 8` (0..7). Position 0 is bit 7 of that byte, and bits then run toward the LSB and on into higher addresses. `bit_ofs` is signed two's complement.
- R3: With s = floor((position + width - 1)/8) + 1 bytes spanned, the access is made as follows. One byte uses size 0 and two bytes use size 1, both at the first byte. Three bytes use size 2 at the first byte, or one byte lower if that byte address is odd. Four bytes use size 2 at the first byte. Five bytes use size 3 at the first byte address rounded down to a multiple of 4. `mem_size` 0/1/2/3 means 1/2/4/8 bytes. `mem_rdata` and `mem_wdata` are right-justified, and the lowest address is the most significant byte of the container.
- R4: Op 0 returns the field sign-extended and op 1 returns it zero-extended. Neither writes memory. `flag_src` is the field placed at bit 31 downward with zeros below.
- R5: Op 3 inverts the field, op 4 clears it and op 5 sets it. Each writes the container back with all other bits unchanged. `result` is the old field zero-extended and `flag_src` is the old field left-aligned.
- R6: Op 2 stores the low `width` bits of `ins_val` into the field and leaves all other bits unchanged. `result` is the old field zero-extended and `flag_src` is `ins_val << (32 - width)`.
- R7: Op 6 returns `bit_ofs` plus the number of leading zero bits of the field, or `bit_ofs` plus width if the field is all zero. It writes no memory, and `flag_src` is the old field left-aligned.
- R8: Every operation makes exactly one read. Ops 2 to 5 follow it with exactly one write of the same address and size. `mem_lock` is high from the read request through the write acknowledge. A request holds its address and direction until `mem_ack`.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R10: `start` is ignored while `busy` is high, and it is ignored with op 7. Neither case causes a bus access or a change to the outputs.
- R11: After reset, `busy`, `done`, `mem_req`, `result` and `flag_src` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| op | input | 3 | Operation code (0..6, 7 ignored) |
| base_addr | input | AW | Byte base address |
| bit_ofs | input | 32 | Signed bit offset |
| width_in | input | 6 | Field width, low 5 bits, 0 = 32 |
| ins_val | input | 32 | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_src | output | 32 | Left-aligned value for N/Z flags |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_lock | output | 1 | Bus held for read-modify-write |
| mem_addr | output | AW | Container byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data, right-justified |
| mem_rdata | input | 64 | Read data, right-justified |
| mem_ack | input | 1 | Bus acknowledge |

## Verification
A new start request can arrive while a read-modify-write is still in flight, including in the cycle where its write is acknowledged. The bench provokes this by raising a conflicting clear on the same field one cycle after a set has been accepted, while the memory model acknowledges after a random delay. The memory image must show only the set, the bus must show one read and one write, and no further access may follow `done`. Alongside this, random operations over random offsets (including negative ones) and widths are compared with a bit-level model of memory.

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit #(
  parameter int AW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   bit_ofs,
  input  logic [5:0]    width_in,
  input  logic [31:0]   ins_val,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic [31:0]   flag_src,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam logic [2:0] OP_EXTS = 3'd0, OP_EXTU = 3'd1, OP_INS = 3'd2,
                         OP_CHG = 3'd3, OP_CLR = 3'd4, OP_SET = 3'd5,
                         OP_FFO = 3'd6, OP_NONE = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} state_t;
  state_t state;

  logic [5:0]    len_c;
  logic [AW-1:0] byte_addr;
  logic [2:0]    span_m1;
  logic [AW-1:0] c_addr;
  logic [1:0]    c_size;
  logic [5:0]    c_bofs;

  assign len_c     = (width_in[4:0] == 5'd0) ? 6'd32 : {1'b0, width_in[4:0]};
  assign byte_addr = base_addr + AW'($signed(bit_ofs) >>> 3);
  assign span_m1   = 3'((6'(bit_ofs[2:0]) + len_c - 6'd1) >> 3);

  always_comb begin
    c_addr = byte_addr;
    c_size = 2'd0;
    c_bofs = 6'(bit_ofs[2:0]);
    case (span_m1)
      3'd0: c_bofs = 6'd56 + 6'(bit_ofs[2:0]);
      3'd1: begin c_size = 2'd1; c_bofs = 6'd48 + 6'(bit_ofs[2:0]); end
      3'd2: begin
        c_size = 2'd2;
        if (byte_addr[0]) begin
          c_addr = byte_addr - AW'(1);
          c_bofs = 6'd40 + 6'(bit_ofs[2:0]);
        end else begin
          c_bofs = 6'd32 + 6'(bit_ofs[2:0]);
        end
      end
      3'd3: begin c_size = 2'd2; c_bofs = 6'd32 + 6'(bit_ofs[2:0]); end
      default: begin
        c_size = 2'd3;
        c_addr = {byte_addr[AW-1:2], 2'b00};
        c_bofs = {1'b0, byte_addr[1:0], 3'b000} + 6'(bit_ofs[2:0]);
      end
    endcase
  end

  logic [2:0]  r_op;
  logic [5:0]  r_len, r_bofs;
  logic [31:0] r_val, r_ofs;
  logic [AW-1:0] r_addr;
  logic [1:0]  r_size;
  logic [63:0] r_wdata;
  logic        is_mod;

  assign is_mod = (r_op == OP_INS) || (r_op == OP_CHG) ||
                  (r_op == OP_CLR) || (r_op == OP_SET);

  function automatic logic [5:0] lead0(input logic [31:0] v);
    lead0 = 6'd32;
    for (int i = 0; i < 32; i++)
      if (v[i]) lead0 = 6'(31 - i);
  endfunction

  logic [63:0] mask, old64, ins64, new_data;
  logic [31:0] old_left, old_zext, old_sext, ins_left, res_c, flag_c;
  logic [5:0]  rsh;

  assign rsh      = 6'd32 - r_len;
  assign mask     = ({64{1'b1}} << (7'd64 - {1'b0, r_len})) >> r_bofs;
  assign old64    = (mem_rdata & mask) << r_bofs;
  assign old_left = old64[63:32];
  assign old_zext = old_left >> rsh;
  assign old_sext = 32'($signed(old_left) >>> rsh);
  assign ins_left = r_val << rsh;
  assign ins64    = {ins_left, 32'b0} >> r_bofs;

  always_comb begin
    case (r_op)
      OP_CHG:  new_data = mem_rdata ^ mask;
      OP_CLR:  new_data = mem_rdata & ~mask;
      OP_SET:  new_data = mem_rdata | mask;
      default: new_data = (mem_rdata & ~mask) | ins64;
    endcase
    case (r_op)
      OP_EXTS: res_c = old_sext;
      OP_FFO:  res_c = r_ofs + 32'((old_left == 32'd0) ? r_len : lead0(old_left));
      default: res_c = old_zext;
    endcase
    flag_c = (r_op == OP_INS) ? ins_left : old_left;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      r_op     <= OP_EXTS;
      r_len    <= 6'd0;
      r_bofs   <= 6'd0;
      r_val    <= 32'd0;
      r_ofs    <= 32'd0;
      r_addr   <= '0;
      r_size   <= 2'd0;
      r_wdata  <= 64'd0;
      result   <= 32'd0;
      flag_src <= 32'd0;
    end else begin
      case (state)
        S_IDLE:
          if (start && op != OP_NONE) begin
            state  <= S_RD;
            r_op   <= op;
            r_len  <= len_c;
            r_bofs <= c_bofs;
            r_val  <= ins_val;
            r_ofs  <= bit_ofs;
            r_addr <= c_addr;
            r_size <= c_size;
          end
        S_RD:
          if (mem_ack) begin
            result   <= res_c;
            flag_src <= flag_c;
            r_wdata  <= new_data;
            state    <= is_mod ? S_WR : S_DONE;
          end
        S_WR:
          if (mem_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_lock  = mem_req && is_mod;
  assign mem_addr  = r_addr;
  assign mem_size  = r_size;
  assign mem_wdata = r_wdata;
endmodule

// File: rtl/bitfield_mem_unit_chk.sv
module bitfield_mem_unit_chk #(
  parameter int AW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic          mem_lock,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size
);
  // R8
  write_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

  // R8
  rmw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && mem_lock) |=> (mem_req && mem_we && mem_lock));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R3
  wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size == 2'd3) |-> (mem_addr[1:0] == 2'b00));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind bitfield_mem_unit bitfield_mem_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_lock(mem_lock),
  .mem_addr(mem_addr), .mem_size(mem_size));

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, busy, done, mem_req, mem_we, mem_lock, mem_ack;
  logic [2:0]  op;
  logic [31:0] base_addr, bit_ofs, ins_val, result, flag_src, mem_addr;
  logic [5:0]  width_in;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  bitfield_mem_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_ofs(bit_ofs), .width_in(width_in), .ins_val(ins_val), .busy(busy),
    .done(done), .result(result), .flag_src(flag_src), .mem_req(mem_req),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  int checks = 0, failures = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] img [0:1023];
  int rd_cnt, wr_cnt, lock_bad, wait_cnt, nb;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_size, wr_size;
  bit op_mod;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    mem_ack = 1'b0; mem_rdata = 64'd0; wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_rdata = 64'd0;
      end else if (mem_req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          nb = 1 << mem_size;
          if (!mem_we) begin
            rd_cnt++; rd_addr = mem_addr; rd_size = mem_size;
            mem_rdata = 64'd0;
            for (int k = 0; k < nb; k++)
              mem_rdata = (mem_rdata << 8) | 64'(mem[10'(mem_addr + 32'(k))]);
          end else begin
            wr_cnt++; wr_addr = mem_addr; wr_size = mem_size;
            for (int k = 0; k < nb; k++)
              mem[10'(mem_addr + 32'(k))] = mem_wdata[8*(nb-1-k) +: 8];
          end
          mem_ack = 1'b1;
          wait_cnt = int'($urandom % 3);
        end
      end
      if (busy && !done && op_mod && !mem_lock) lock_bad++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit gbit(input int a);
    return img[a >> 3][7 - (a & 7)];
  endfunction

  task automatic run_op(input int o, input int base, input int ofs, input int w,
                        input logic [31:0] val, input bit intrude);
    int abs_b, len, bp, span, ea, first, mism;
    logic [31:0] fld, exp_res, exp_flag;
    logic [1:0] es;
    bit v;
    string rq;
    for (int k = 0; k < 1024; k++) img[k] = mem[k];
    abs_b = base * 8 + ofs;
    len = (w % 32 == 0) ? 32 : w % 32;
    fld = 32'd0; first = len;
    for (int i = 0; i < len; i++) begin
      fld = (fld << 1) | 32'(gbit(abs_b + i));
      if (gbit(abs_b + i) && first == len) first = i;
    end
    exp_flag = fld << (32 - len);
    case (o)
      0: exp_res = (len < 32 && fld[len-1]) ? (fld | (32'hFFFF_FFFF << len)) : fld;
      6: exp_res = 32'(ofs + first);
      default: exp_res = fld;
    endcase
    if (o == 2) exp_flag = val << (32 - len);
    for (int i = 0; i < len; i++) begin
      v = gbit(abs_b + i);
      case (o)
        2: v = val[len-1-i];
        3: v = ~v;
        4: v = 1'b0;
        5: v = 1'b1;
        default: ;
      endcase
      img[(abs_b + i) >> 3][7 - ((abs_b + i) & 7)] = v;
    end
    case (o)
      0, 1: rq = "R4";
      2: rq = "R6";
      6: rq = "R7";
      default: rq = "R5";
    endcase
    ea = abs_b / 8; bp = abs_b % 8; span = (bp + len - 1) / 8 + 1;
    case (span)
      1: es = 2'd0;
      2: es = 2'd1;
      3: begin es = 2'd2; if (ea % 2 == 1) ea--; end
      4: es = 2'd2;
      default: begin es = 2'd3; ea = ea & ~3; end
    endcase
    op_mod = (o >= 2 && o <= 5);
    rd_cnt = 0; wr_cnt = 0; lock_bad = 0;
    @(negedge clk);
    start = 1'b1; op = 3'(o); base_addr = 32'(base); bit_ofs = 32'(ofs);
    width_in = 6'(w); ins_val = val;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      start = 1'b1; op = 3'd4;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({rq, " result"}, 64'(result), 64'(exp_res));
    chk({rq, " flag_src"}, 64'(flag_src), 64'(exp_flag));
    mism = 0;
    for (int k = 0; k < 1024; k++) if (mem[k] !== img[k]) mism++;
    chk({rq, " memory image mismatching bytes"}, 64'(mism), 64'd0);
    chk("R3 container address", 64'(rd_addr), 64'(ea));
    chk("R3 container size", 64'(rd_size), 64'(es));
    chk("R8 read count", 64'(rd_cnt), 64'd1);
    chk("R8 write count", 64'(wr_cnt), op_mod ? 64'd1 : 64'd0);
    if (op_mod) chk("R8 write address", 64'(wr_addr), 64'(ea));
    chk("R8 lock held during rmw", 64'(lock_bad), 64'd0);
    @(negedge clk);
    chk("R9 done single pulse", 64'(done), 64'd0);
    if (intrude) begin
      repeat (4) @(negedge clk);
      chk("R10 no access from start while busy", 64'(rd_cnt), 64'd1);
      chk("R10 idle after intrusion", 64'(busy), 64'd0);
    end
  endtask

  initial begin
    logic [31:0] keep_r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; op = 3'd0; base_addr = 32'd0; bit_ofs = 32'd0;
    width_in = 6'd0; ins_val = 32'd0; op_mod = 1'b0;
    for (int k = 0; k < 1024; k++) mem[k] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", 64'(busy), 64'd0);
    chk("R11 done after reset", 64'(done), 64'd0);
    chk("R11 mem_req after reset", 64'(mem_req), 64'd0);
    chk("R11 result after reset", 64'(result), 64'd0);
    chk("R11 flag_src after reset", 64'(flag_src), 64'd0);

    // R1 width 0 means 32, 5-byte spans, aligned and unaligned
    run_op(1, 200, 3, 0, 32'd0, 1'b0);
    run_op(0, 201, 3, 32, 32'd0, 1'b0);
    run_op(2, 203, 5, 0, 32'hDEAD_BEEF, 1'b0);
    // R1 width 33 behaves as 1
    run_op(5, 210, 6, 33, 32'd0, 1'b0);
    // R2 negative offsets
    run_op(1, 300, -1, 4, 32'd0, 1'b0);
    run_op(3, 300, -9, 12, 32'd0, 1'b0);
    run_op(0, 320, -3, 7, 32'd0, 1'b0);
    // R3 three-byte spans at odd and even address
    run_op(4, 301, 4, 16, 32'd0, 1'b0);
    run_op(1, 302, 4, 16, 32'd0, 1'b0);
    // R7 all-zero field and leading zeros with negative offset
    for (int k = 396; k < 410; k++) mem[k] = 8'h00;
    run_op(6, 400, 5, 10, 32'd0, 1'b0);
    mem[401] = 8'h04;
    run_op(6, 400, -3, 20, 32'd0, 1'b0);
    // R6 insert ignores value bits above width
    run_op(2, 500, 2, 9, 32'hFFFF_FE5A, 1'b0);
    // R10 conflicting clear raised while a set is in flight
    run_op(5, 520, 2, 8, 32'd0, 1'b1);
    // R10 op 7 is ignored
    keep_r = result;
    rd_cnt = 0;
    @(negedge clk);
    start = 1'b1; op = 3'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 op 7 busy", 64'(busy), 64'd0);
    chk("R10 op 7 bus access", 64'(rd_cnt), 64'd0);
    chk("R10 op 7 result unchanged", 64'(result), 64'(keep_r));

    for (int n = 0; n < 300; n++)
      run_op(int'($urandom % 7), 100 + int'($urandom % 800),
             int'($urandom % 801) - 400, int'($urandom % 64), $urandom, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule